// File: doc/BRIEF.md
# Asynchronous Serial Receive Channel with Error Flags

This block receives characters from an idle-high asynchronous serial line. It runs on the system clock and advances its bit timing on a one-cycle enable tick, which arrives sixteen times per bit period (the ratio is a parameter). A falling edge on the line arms the receiver. The start bit is then confirmed half a bit later, which rejects short glitches. Each data bit and the optional parity bit are sampled at the middle of the bit, data least significant bit first. The first stop bit is sampled in the same way.

When a character completes, the block checks parity, the first stop bit and whether the previous character is still unread. Good characters are placed in the data register and set the data-full flag. A bad stop bit or a parity mismatch sets a framing or parity error flag. In that case the character is still written to the data register, but the data-full flag stays clear. A character that completes while the data-full flag is still set raises the overrun flag and is discarded. While any error flag is set, the receiver ignores the line.

Software clears each flag with a one-cycle strobe. If a strobe arrives in the same cycle as a set of that flag, the set wins. Two interrupt requests, data-ready and error, are gated by one enable input.

Top module: `uart_rx_err`

## Requirements
- R1: After reset, the data register holds zero, and the data-full flag, all three error flags and both interrupt requests are 0.
- R2: A character is a 0 start bit, then DATA_W data bits least significant bit first, then an optional parity bit, then one or two stop bits. A good character is stored in the data register and sets the data-full flag.
- R3: A low pulse on the line is rejected if the line is high again at the middle of the start bit. The receiver then waits for the next falling edge and receives the next character normally.
- R4: With parity enabled, the data bits plus the parity bit must hold an even number of 1s when the odd-select input is 0, and an odd number when it is 1. A mismatch sets the parity error flag, the character is still stored, and the data-full flag stays 0.
- R5: A 0 in the first stop bit sets the framing error flag, the character is still stored, and the data-full flag stays 0.
- R6: In two-stop-bit mode, only the first stop bit is checked. A 0 in the second stop bit sets no flag, and the character is accepted.
- R7: If a character completes while the data-full flag is 1, the overrun flag is set. The data register keeps the earlier character and the data-full flag stays 1.
- R8: While any error flag is 1, arriving characters are ignored. The data register and the flags do not change. After the flags are cleared, reception resumes.
- R9: A one-cycle clear strobe clears its flag. A clear in the same cycle as a set of the same flag is ignored.
- R10: The data-ready request equals the enable input AND the data-full flag. The error request equals the enable input AND the OR of the three error flags. Both are registered one cycle behind their inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd_i | input | 1 | Serial line, idle high, asynchronous |
| tick_i | input | 1 | One-cycle oversampling enable, OVS per bit |
| par_en_i | input | 1 | Parity bit present and checked |
| par_odd_i | input | 1 | 1 = odd parity, 0 = even parity |
| two_stop_i | input | 1 | 1 = two stop bits per character |
| rx_ie_i | input | 1 | Enable for both interrupt requests |
| clr_full_i | input | 1 | Clear strobe for the data-full flag |
| clr_ovr_i | input | 1 | Clear strobe for the overrun flag |
| clr_frm_i | input | 1 | Clear strobe for the framing error flag |
| clr_par_i | input | 1 | Clear strobe for the parity error flag |
| rx_data_o | output | DATA_W | Receive data register |
| full_o | output | 1 | Data-full flag |
| ovr_err_o | output | 1 | Overrun error flag |
| frm_err_o | output | 1 | Framing error flag |
| par_err_o | output | 1 | Parity error flag |
| irq_rx_o | output | 1 | Data-ready interrupt request |
| irq_err_o | output | 1 | Receive error interrupt request |

## Verification
The bench builds the block with DATA_W = 8, OVS = 16 and a two-stage line synchronizer, and raises the tick every fourth clock, so one bit lasts 64 clocks. These values let a whole character, including two stop bits, complete in well under a thousand cycles. That short frame is what makes the overrun and error-lockout sequences practical, since they need several back-to-back characters. A three-tick low pulse is shorter than the half-bit confirmation window of eight ticks, which puts glitch rejection within reach. Holding a clear strobe across a whole character lands it on the exact completion cycle, which tests the rule that a set beats a clear.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP,
    RX_STOP2
  } rx_state_e;

endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  // Resets to the idle-high line level.
  always_ff @(posedge clk) begin
    if (rst) chain_q <= '1;
    else     chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/rx_frame.sv
module rx_frame
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              line_i,
  input  logic              rx_en_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              two_stop_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              stop_ok_o,
  output logic              par_ok_o,
  output logic              busy_o
);

  localparam int CNT_W = $clog2(OVS);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] HALF_M1 = CNT_W'(OVS/2 - 1);
  localparam logic [CNT_W-1:0] FULL_M1 = CNT_W'(OVS - 1);
  localparam logic [IDX_W-1:0] LAST_IX = IDX_W'(DATA_W - 1);

  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] shreg_q;
  logic              last_q;
  logic              par_bit_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= RX_IDLE;
      cnt_q     <= '0;
      idx_q     <= '0;
      shreg_q   <= '0;
      last_q    <= 1'b1;
      par_bit_q <= 1'b0;
      done_o    <= 1'b0;
      data_o    <= '0;
      stop_ok_o <= 1'b1;
      par_ok_o  <= 1'b1;
    end else begin
      done_o <= 1'b0;
      if (tick_i) begin
        last_q <= line_i;
        case (state_q)
          RX_IDLE: begin
            // Arm only on a high-to-low edge, and only while error-free.
            if (rx_en_i && last_q && !line_i) begin
              state_q <= RX_START;
              cnt_q   <= '0;
            end
          end
          RX_START: begin
            if (cnt_q == HALF_M1) begin
              cnt_q <= '0;
              idx_q <= '0;
              state_q <= line_i ? RX_IDLE : RX_DATA;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          RX_DATA: begin
            if (cnt_q == FULL_M1) begin
              cnt_q   <= '0;
              shreg_q <= {line_i, shreg_q[DATA_W-1:1]};
              if (idx_q == LAST_IX) state_q <= par_en_i ? RX_PAR : RX_STOP;
              else                  idx_q   <= idx_q + 1'b1;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          RX_PAR: begin
            if (cnt_q == FULL_M1) begin
              cnt_q     <= '0;
              par_bit_q <= line_i;
              state_q   <= RX_STOP;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          RX_STOP: begin
            if (cnt_q == FULL_M1) begin
              cnt_q     <= '0;
              done_o    <= 1'b1;
              data_o    <= shreg_q;
              stop_ok_o <= line_i;
              par_ok_o  <= !par_en_i || (((^shreg_q) ^ par_bit_q) == par_odd_i);
              state_q   <= two_stop_i ? RX_STOP2 : RX_IDLE;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          RX_STOP2: begin
            // Second stop period is timed but never sampled.
            if (cnt_q == FULL_M1) begin
              cnt_q   <= '0;
              state_q <= RX_IDLE;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: state_q <= RX_IDLE;
        endcase
      end
    end
  end

  assign busy_o = (state_q != RX_IDLE);

  // R8
  no_start_when_locked_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(rx_en_i));

  // R2
  done_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

endmodule

// File: rtl/rx_status.sv
module rx_status #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              done_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              stop_ok_i,
  input  logic              par_ok_i,
  input  logic              rx_ie_i,
  input  logic              clr_full_i,
  input  logic              clr_ovr_i,
  input  logic              clr_frm_i,
  input  logic              clr_par_i,
  output logic [DATA_W-1:0] data_o,
  output logic              full_o,
  output logic              ovr_o,
  output logic              frm_o,
  output logic              par_o,
  output logic              irq_rx_o,
  output logic              irq_err_o,
  output logic              rx_en_o
);

  logic full_n, ovr_n, frm_n, par_n, load;

  always_comb begin
    full_n = full_o & ~clr_full_i;
    ovr_n  = ovr_o  & ~clr_ovr_i;
    frm_n  = frm_o  & ~clr_frm_i;
    par_n  = par_o  & ~clr_par_i;
    load   = 1'b0;
    if (done_i) begin
      if (full_o) begin
        ovr_n = 1'b1;
      end else begin
        load = 1'b1;
        if (stop_ok_i && par_ok_i) full_n = 1'b1;
      end
      if (!stop_ok_i) frm_n = 1'b1;
      if (!par_ok_i)  par_n = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_o    <= '0;
      full_o    <= 1'b0;
      ovr_o     <= 1'b0;
      frm_o     <= 1'b0;
      par_o     <= 1'b0;
      irq_rx_o  <= 1'b0;
      irq_err_o <= 1'b0;
    end else begin
      if (load) data_o <= data_i;
      full_o    <= full_n;
      ovr_o     <= ovr_n;
      frm_o     <= frm_n;
      par_o     <= par_n;
      irq_rx_o  <= rx_ie_i & full_n;
      irq_err_o <= rx_ie_i & (ovr_n | frm_n | par_n);
    end
  end

  assign rx_en_o = ~(ovr_o | frm_o | par_o);

  // R7
  overrun_keeps_data_chk: assert property (@(posedge clk) disable iff (rst)
    (done_i && full_o) |=> ($stable(data_o) && full_o && ovr_o));

  // R5
  bad_frame_loads_chk: assert property (@(posedge clk) disable iff (rst)
    (done_i && !full_o && !(stop_ok_i && par_ok_i)) |=> (!full_o && data_o == $past(data_i)));

  // R9
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (done_i && !full_o && stop_ok_i && par_ok_i) |=> full_o);

  // R10
  irq_err_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
    irq_err_o |-> (ovr_o || frm_o || par_o));

  // R10
  irq_rx_needs_full_chk: assert property (@(posedge clk) disable iff (rst)
    irq_rx_o |-> full_o);

endmodule

// File: rtl/uart_rx_err.sv
module uart_rx_err #(
  parameter int DATA_W      = 8,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rxd_i,
  input  logic              tick_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              two_stop_i,
  input  logic              rx_ie_i,
  input  logic              clr_full_i,
  input  logic              clr_ovr_i,
  input  logic              clr_frm_i,
  input  logic              clr_par_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              full_o,
  output logic              ovr_err_o,
  output logic              frm_err_o,
  output logic              par_err_o,
  output logic              irq_rx_o,
  output logic              irq_err_o
);

  logic              line_s;
  logic              rx_en;
  logic              done;
  logic [DATA_W-1:0] frame_data;
  logic              stop_ok;
  logic              par_ok;
  logic              busy;

  rx_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk (clk),
    .rst (rst),
    .d_i (rxd_i),
    .q_o (line_s)
  );

  rx_frame #(.DATA_W(DATA_W), .OVS(OVS)) frame_i (
    .clk        (clk),
    .rst        (rst),
    .tick_i     (tick_i),
    .line_i     (line_s),
    .rx_en_i    (rx_en),
    .par_en_i   (par_en_i),
    .par_odd_i  (par_odd_i),
    .two_stop_i (two_stop_i),
    .done_o     (done),
    .data_o     (frame_data),
    .stop_ok_o  (stop_ok),
    .par_ok_o   (par_ok),
    .busy_o     (busy)
  );

  rx_status #(.DATA_W(DATA_W)) status_i (
    .clk        (clk),
    .rst        (rst),
    .done_i     (done),
    .data_i     (frame_data),
    .stop_ok_i  (stop_ok),
    .par_ok_i   (par_ok),
    .rx_ie_i    (rx_ie_i),
    .clr_full_i (clr_full_i),
    .clr_ovr_i  (clr_ovr_i),
    .clr_frm_i  (clr_frm_i),
    .clr_par_i  (clr_par_i),
    .data_o     (rx_data_o),
    .full_o     (full_o),
    .ovr_o      (ovr_err_o),
    .frm_o      (frm_err_o),
    .par_o      (par_err_o),
    .irq_rx_o   (irq_rx_o),
    .irq_err_o  (irq_err_o),
    .rx_en_o    (rx_en)
  );

  // R8
  locked_while_error_chk: assert property (@(posedge clk) disable iff (rst)
    (ovr_err_o || frm_err_o || par_err_o) |-> !done);

endmodule

// File: tb/uart_rx_err_tb_top.sv
module uart_rx_err_tb_top;

  localparam int DW       = 8;
  localparam int BIT_CLKS = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rxd = 1'b1;
  logic tick;
  logic [1:0] tick_cnt = '0;
  logic par_en = 1'b0, par_odd = 1'b0, two_stop = 1'b0, rx_ie = 1'b0;
  logic clr_full = 1'b0, clr_ovr = 1'b0, clr_frm = 1'b0, clr_par = 1'b0;
  logic [DW-1:0] rx_data;
  logic full, ovr, frm, perr, irq_rx, irq_err;

  int checks = 0;
  int fails  = 0;
  logic watch = 1'b0;
  int   seen_full = 0;

  always #2 clk = ~clk;

  always @(posedge clk) tick_cnt <= tick_cnt + 2'd1;
  assign tick = (tick_cnt == 2'd0);

  uart_rx_err #(.DATA_W(DW), .OVS(16), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst(rst), .rxd_i(rxd), .tick_i(tick),
    .par_en_i(par_en), .par_odd_i(par_odd), .two_stop_i(two_stop), .rx_ie_i(rx_ie),
    .clr_full_i(clr_full), .clr_ovr_i(clr_ovr), .clr_frm_i(clr_frm), .clr_par_i(clr_par),
    .rx_data_o(rx_data), .full_o(full), .ovr_err_o(ovr), .frm_err_o(frm),
    .par_err_o(perr), .irq_rx_o(irq_rx), .irq_err_o(irq_err)
  );

  always @(negedge clk) if (watch && full) seen_full++;

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive_bit(input logic v);
    rxd = v;
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  // Sends one character; flip inverts the parity bit, s1/s2 are the stop bits.
  task automatic send(input logic [DW-1:0] d, input logic flip, input logic s1, input logic s2);
    drive_bit(1'b0);
    for (int i = 0; i < DW; i++) drive_bit(d[i]);
    if (par_en) drive_bit((^d) ^ par_odd ^ flip);
    drive_bit(s1);
    if (two_stop) drive_bit(s2);
    rxd = 1'b1;
    repeat (2 * BIT_CLKS) @(negedge clk);
  endtask

  task automatic pulse_clear(input logic f, input logic o, input logic r, input logic p);
    clr_full = f; clr_ovr = o; clr_frm = r; clr_par = p;
    @(negedge clk);
    clr_full = 1'b0; clr_ovr = 1'b0; clr_frm = 1'b0; clr_par = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1", "data", 32'(rx_data), 32'h0);
    check("R1", "flags", {full, ovr, frm, perr}, 4'b0000);
    check("R1", "irqs", {irq_rx, irq_err}, 2'b00);
  endtask

  task automatic t_basic();
    send(8'hA5, 1'b0, 1'b1, 1'b1);
    check("R2", "data A5", 32'(rx_data), 32'hA5);
    check("R2", "full", 32'(full), 32'h1);
    check("R10", "irq_rx gated off", 32'(irq_rx), 32'h0);
    rx_ie = 1'b1;
    repeat (2) @(negedge clk);
    check("R10", "irq_rx enabled", 32'(irq_rx), 32'h1);
    pulse_clear(1'b1, 1'b0, 1'b0, 1'b0);
    check("R9", "full cleared", 32'(full), 32'h0);
    check("R10", "irq_rx drops", 32'(irq_rx), 32'h0);
    send(8'h3C, 1'b0, 1'b1, 1'b1);
    check("R2", "data 3C lsb first", 32'(rx_data), 32'h3C);
    pulse_clear(1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_overrun_lockout();
    send(8'h11, 1'b0, 1'b1, 1'b1);
    send(8'h22, 1'b0, 1'b1, 1'b1);
    check("R7", "data kept", 32'(rx_data), 32'h11);
    check("R7", "full+ovr", {full, ovr}, 2'b11);
    check("R10", "irq_err", 32'(irq_err), 32'h1);
    pulse_clear(1'b1, 1'b0, 1'b0, 1'b0);
    send(8'h33, 1'b0, 1'b1, 1'b1);
    check("R8", "locked data", 32'(rx_data), 32'h11);
    check("R8", "locked flags", {full, ovr}, 2'b01);
    pulse_clear(1'b0, 1'b1, 1'b0, 1'b0);
    check("R9", "ovr cleared", {ovr, irq_err}, 2'b00);
    send(8'h44, 1'b0, 1'b1, 1'b1);
    check("R8", "resumes", {24'h0, rx_data}, 32'h44);
    pulse_clear(1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_parity();
    par_en = 1'b1; par_odd = 1'b0;
    send(8'h07, 1'b0, 1'b1, 1'b1);
    check("R4", "even ok", {full, perr}, 2'b10);
    pulse_clear(1'b1, 1'b0, 1'b0, 1'b0);
    par_odd = 1'b1;
    send(8'h07, 1'b0, 1'b1, 1'b1);
    check("R4", "odd ok", {full, perr}, 2'b10);
    pulse_clear(1'b1, 1'b0, 1'b0, 1'b0);
    par_odd = 1'b0;
    send(8'h5A, 1'b1, 1'b1, 1'b1);
    check("R4", "mismatch flags", {full, perr}, 2'b01);
    check("R4", "mismatch data", 32'(rx_data), 32'h5A);
    pulse_clear(1'b0, 1'b0, 1'b0, 1'b1);
    par_en = 1'b0;
  endtask

  task automatic t_framing();
    send(8'h81, 1'b0, 1'b0, 1'b1);
    check("R5", "frm flags", {full, frm}, 2'b01);
    check("R5", "frm data", 32'(rx_data), 32'h81);
    pulse_clear(1'b0, 1'b0, 1'b1, 1'b0);
    check("R9", "frm cleared", 32'(frm), 32'h0);
  endtask

  task automatic t_two_stop();
    two_stop = 1'b1;
    send(8'hE2, 1'b0, 1'b1, 1'b0);
    check("R6", "2nd stop ignored", {full, frm}, 2'b10);
    check("R6", "data", 32'(rx_data), 32'hE2);
    pulse_clear(1'b1, 1'b0, 1'b0, 1'b0);
    send(8'h19, 1'b0, 1'b0, 1'b1);
    check("R6", "1st stop checked", {full, frm}, 2'b01);
    pulse_clear(1'b0, 1'b0, 1'b1, 1'b0);
    two_stop = 1'b0;
  endtask

  task automatic t_glitch();
    rxd = 1'b0;
    repeat (12) @(negedge clk);
    rxd = 1'b1;
    repeat (3 * BIT_CLKS) @(negedge clk);
    check("R3", "glitch no frame", {full, frm, perr}, 3'b000);
    check("R3", "glitch data", 32'(rx_data), 32'h19);
    send(8'h96, 1'b0, 1'b1, 1'b1);
    check("R3", "after glitch", {23'h0, full, rx_data}, {23'h0, 1'b1, 8'h96});
    pulse_clear(1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_set_wins();
    seen_full = 0;
    watch = 1'b1;
    clr_full = 1'b1;
    send(8'hC3, 1'b0, 1'b1, 1'b1);
    clr_full = 1'b0;
    watch = 1'b0;
    check("R9", "set beats clear", 32'(seen_full), 32'h1);
    check("R9", "data", 32'(rx_data), 32'hC3);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (4 * BIT_CLKS) @(negedge clk);
    t_reset();
    t_basic();
    t_overrun_lockout();
    t_parity();
    t_framing();
    t_two_stop();
    t_glitch();
    t_set_wins();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule